// File: doc/BRIEF.md
# Return From Trap Unit

This unit settles what a return-from-trap instruction does. It looks at the processor status bits, the debug-mode flag and the debug field carried in the instruction. From these it produces the next program counter, the new supervisor and enable-traps bits, and a request to leave debug mode. It also raises a halt request or an illegal-instruction request when the status word forbids the return.

The checks are resolved in a fixed order:

1. A clear supervisor bit wins over everything else.
2. A set enable-traps bit comes next.
3. A return from normal state is tried after that.
4. A return from debug state is tried last.

If none of these applies, the instruction only steps past itself.

The unit updates its outputs one clock after a valid strobe. Those outputs hold steady until the next strobe. The request outputs and the done flag are one-cycle pulses.

Top module: `rett_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, next_pc_o is 0, sup_o and et_o are 0, and done_o, halt_o, illegal_o and dbg_clear_o are 0.
- R2: A strobe with supervisor 0 and enable-traps 0 gives, one cycle later, halt_o=1, illegal_o=0, next_pc_o = pc_i+4, sup_o=0 and et_o=0, whatever the debug mode and debug field are.
- R3: A strobe with supervisor 0 and enable-traps 1 gives, one cycle later, no halt and no illegal request, next_pc_o = pc_i+4, sup_o=0 and et_o=1.
- R4: A strobe with supervisor 1 and enable-traps 1 gives, one cycle later, illegal_o=1, halt_o=0, next_pc_o = pc_i+4, and sup_o=1, et_o=1 unchanged, even when the mode and field would match a return.
- R5: A strobe with supervisor 1, enable-traps 0, debug mode 0 and debug field 0 gives next_pc_o = trap_pc_i, et_o=1 and sup_o = psup_i, with no request pulses.
- R6: A strobe with supervisor 1, enable-traps 0, debug mode 1 and debug field 1 gives next_pc_o = dbg_pc_i, et_o = dbg_et_i, sup_o = dbg_sup_i and dbg_clear_o=1.
- R7: A strobe with supervisor 1 and enable-traps 0 whose debug field does not match the debug mode gives next_pc_o = pc_i+4, sup_o=1, et_o=0 and no pulses.
- R8: done_o, halt_o, illegal_o and dbg_clear_o are high only in the cycle after a strobe. Without a strobe, next_pc_o, sup_o and et_o keep their values.
- R9: The PC+4 sum wraps modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Strobe: evaluate a return instruction this cycle |
| pc_i | input | PC_W | Address of the return instruction |
| sup_i | input | 1 | Current supervisor bit |
| et_i | input | 1 | Current enable-traps bit |
| psup_i | input | 1 | Previous-supervisor bit |
| dbg_mode_i | input | 1 | Processor is in debug state |
| dbg_field_i | input | 1 | Debug field of the instruction |
| trap_pc_i | input | PC_W | Saved trap PC |
| dbg_pc_i | input | PC_W | Saved debug PC |
| dbg_et_i | input | 1 | Saved enable-traps bit for debug return |
| dbg_sup_i | input | 1 | Saved supervisor bit for debug return |
| done_o | output | 1 | Result registered this cycle |
| next_pc_o | output | PC_W | Next program counter |
| sup_o | output | 1 | New supervisor bit |
| et_o | output | 1 | New enable-traps bit |
| dbg_clear_o | output | 1 | Pulse: leave debug state |
| halt_o | output | 1 | Pulse: halt request |
| illegal_o | output | 1 | Pulse: illegal-instruction request |

## Verification
On every cycle, the assertions relate each strobed input combination to the registered result one cycle later. This covers the five outcomes and their priority. They also check that the request pulses never appear without a preceding strobe, and that halt and illegal never coincide.

Some behaviour only the bench scenarios show:
- values held across idle stretches;
- the wrap of PC+4 at the top of the address space;
- long random mixes of status, mode and field, compared against an independent model.

// File: rtl/rett_pkg.sv
package rett_pkg;
  // Outcome of the prioritised checks on a return-from-trap instruction
  typedef enum logic [2:0] {
    RK_HALT     = 3'd0, // supervisor clear, traps disabled
    RK_STEP     = 3'd1, // supervisor clear, traps enabled
    RK_ILLEGAL  = 3'd2, // supervisor set, traps enabled
    RK_NORMAL   = 3'd3, // return from normal state
    RK_DEBUG    = 3'd4, // return from debug state
    RK_MISMATCH = 3'd5  // field does not match mode
  } rett_kind_e;
endpackage

// File: rtl/rett_classify.sv
module rett_classify
  import rett_pkg::*;
(
  input  logic       sup,
  input  logic       et,
  input  logic       dbg_mode,
  input  logic       dbg_field,
  output rett_kind_e kind
);
  always_comb begin
    if (!sup) begin
      kind = et ? RK_STEP : RK_HALT;
    end else if (et) begin
      kind = RK_ILLEGAL;
    end else if (!dbg_mode && !dbg_field) begin
      kind = RK_NORMAL;
    end else if (dbg_mode && dbg_field) begin
      kind = RK_DEBUG;
    end else begin
      kind = RK_MISMATCH;
    end
  end
endmodule

// File: rtl/rett_select.sv
module rett_select
  import rett_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4
) (
  input  rett_kind_e        kind,
  input  logic [PC_W-1:0]   pc,
  input  logic              sup,
  input  logic              et,
  input  logic              psup,
  input  logic [PC_W-1:0]   trap_pc,
  input  logic [PC_W-1:0]   dbg_pc,
  input  logic              dbg_et,
  input  logic              dbg_sup,
  output logic [PC_W-1:0]   nxt_pc,
  output logic              nxt_sup,
  output logic              nxt_et,
  output logic              halt,
  output logic              illegal,
  output logic              dbg_clear
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  logic [PC_W-1:0] seq_pc;
  assign seq_pc = pc + STEP;

  always_comb begin
    nxt_pc    = seq_pc;
    nxt_sup   = sup;
    nxt_et    = et;
    halt      = 1'b0;
    illegal   = 1'b0;
    dbg_clear = 1'b0;
    unique case (kind)
      RK_HALT:    halt = 1'b1;
      RK_ILLEGAL: illegal = 1'b1;
      RK_NORMAL: begin
        nxt_pc  = trap_pc;
        nxt_et  = 1'b1;
        nxt_sup = psup;
      end
      RK_DEBUG: begin
        nxt_pc    = dbg_pc;
        nxt_et    = dbg_et;
        nxt_sup   = dbg_sup;
        dbg_clear = 1'b1;
      end
      default: ; // step and mismatch keep the defaults
    endcase
  end
endmodule

// File: rtl/rett_unit.sv
module rett_unit
  import rett_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            sup_i,
  input  logic            et_i,
  input  logic            psup_i,
  input  logic            dbg_mode_i,
  input  logic            dbg_field_i,
  input  logic [PC_W-1:0] trap_pc_i,
  input  logic [PC_W-1:0] dbg_pc_i,
  input  logic            dbg_et_i,
  input  logic            dbg_sup_i,
  output logic            done_o,
  output logic [PC_W-1:0] next_pc_o,
  output logic            sup_o,
  output logic            et_o,
  output logic            dbg_clear_o,
  output logic            halt_o,
  output logic            illegal_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  rett_kind_e      kind;
  logic [PC_W-1:0] c_pc;
  logic            c_sup, c_et, c_halt, c_ill, c_dclr;

  rett_classify u_classify (
    .sup      (sup_i),
    .et       (et_i),
    .dbg_mode (dbg_mode_i),
    .dbg_field(dbg_field_i),
    .kind     (kind)
  );

  rett_select #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES)) u_select (
    .kind     (kind),
    .pc       (pc_i),
    .sup      (sup_i),
    .et       (et_i),
    .psup     (psup_i),
    .trap_pc  (trap_pc_i),
    .dbg_pc   (dbg_pc_i),
    .dbg_et   (dbg_et_i),
    .dbg_sup  (dbg_sup_i),
    .nxt_pc   (c_pc),
    .nxt_sup  (c_sup),
    .nxt_et   (c_et),
    .halt     (c_halt),
    .illegal  (c_ill),
    .dbg_clear(c_dclr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o      <= 1'b0;
      next_pc_o   <= '0;
      sup_o       <= 1'b0;
      et_o        <= 1'b0;
      dbg_clear_o <= 1'b0;
      halt_o      <= 1'b0;
      illegal_o   <= 1'b0;
    end else begin
      done_o      <= valid_i;
      dbg_clear_o <= valid_i & c_dclr;
      halt_o      <= valid_i & c_halt;
      illegal_o   <= valid_i & c_ill;
      if (valid_i) begin
        next_pc_o <= c_pc;
        sup_o     <= c_sup;
        et_o      <= c_et;
      end
    end
  end

  AST_HALT_WHEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
    valid_i && !sup_i && !et_i |=> halt_o && !illegal_o && !sup_o && !et_o
      && next_pc_o == $past(pc_i) + STEP); // R2
  AST_USER_STEP: assert property (@(posedge clk) disable iff (rst)
    valid_i && !sup_i && et_i |=> !halt_o && !illegal_o && !dbg_clear_o
      && !sup_o && et_o); // R3
  AST_ILLEGAL_FIRST: assert property (@(posedge clk) disable iff (rst)
    valid_i && sup_i && et_i |=> illegal_o && !halt_o && !dbg_clear_o
      && sup_o && et_o); // R4
  AST_NORMAL_RETURN: assert property (@(posedge clk) disable iff (rst)
    valid_i && sup_i && !et_i && !dbg_mode_i && !dbg_field_i |=>
      et_o && sup_o == $past(psup_i) && next_pc_o == $past(trap_pc_i)
      && !dbg_clear_o); // R5
  AST_DEBUG_RETURN: assert property (@(posedge clk) disable iff (rst)
    valid_i && sup_i && !et_i && dbg_mode_i && dbg_field_i |=>
      dbg_clear_o && et_o == $past(dbg_et_i) && sup_o == $past(dbg_sup_i)
      && next_pc_o == $past(dbg_pc_i)); // R6
  AST_MISMATCH_STEP: assert property (@(posedge clk) disable iff (rst)
    valid_i && sup_i && !et_i && (dbg_mode_i != dbg_field_i) |=>
      sup_o && !et_o && !halt_o && !illegal_o && !dbg_clear_o); // R7
  AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !done_o && !halt_o && !illegal_o && !dbg_clear_o
      && $stable(next_pc_o) && $stable(sup_o) && $stable(et_o)); // R8
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
    $countones({halt_o, illegal_o, dbg_clear_o}) <= 1); // R8
endmodule

// File: tb/test_rett_unit.sv
`timescale 1ns/1ps
module test_rett_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [31:0] pc_i = '0, trap_pc_i = '0, dbg_pc_i = '0;
  logic        sup_i = 0, et_i = 0, psup_i = 0, dbg_mode_i = 0, dbg_field_i = 0;
  logic        dbg_et_i = 0, dbg_sup_i = 0;
  logic        done_o, sup_o, et_o, dbg_clear_o, halt_o, illegal_o;
  logic [31:0] next_pc_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  logic [31:0] e_pc = '0;
  logic        e_sup = 0, e_et = 0, e_done = 0, e_halt = 0, e_ill = 0, e_dclr = 0;
  string       e_tag = "R1";

  always #2.5 clk = ~clk;

  rett_unit i_rett_unit (
    .clk(clk), .rst(rst), .valid_i(valid_i), .pc_i(pc_i), .sup_i(sup_i),
    .et_i(et_i), .psup_i(psup_i), .dbg_mode_i(dbg_mode_i),
    .dbg_field_i(dbg_field_i), .trap_pc_i(trap_pc_i), .dbg_pc_i(dbg_pc_i),
    .dbg_et_i(dbg_et_i), .dbg_sup_i(dbg_sup_i), .done_o(done_o),
    .next_pc_o(next_pc_o), .sup_o(sup_o), .et_o(et_o),
    .dbg_clear_o(dbg_clear_o), .halt_o(halt_o), .illegal_o(illegal_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(e_tag, "done",      32'(done_o),      32'(e_done));
    chk(e_tag, "next_pc",   next_pc_o,        e_pc);
    chk(e_tag, "sup",       32'(sup_o),       32'(e_sup));
    chk(e_tag, "et",        32'(et_o),        32'(e_et));
    chk(e_tag, "halt",      32'(halt_o),      32'(e_halt));
    chk(e_tag, "illegal",   32'(illegal_o),   32'(e_ill));
    chk(e_tag, "dbg_clear", 32'(dbg_clear_o), 32'(e_dclr));
  endtask

  // Called at a negedge: apply stimulus, predict, then check after the edge.
  task automatic drive(bit v, logic [31:0] pc, bit s, bit e, bit ps, bit dm,
                       bit df, logic [31:0] tpc, logic [31:0] dpc, bit de, bit ds);
    valid_i = v; pc_i = pc; sup_i = s; et_i = e; psup_i = ps;
    dbg_mode_i = dm; dbg_field_i = df; trap_pc_i = tpc; dbg_pc_i = dpc;
    dbg_et_i = de; dbg_sup_i = ds;
    e_done = v; e_halt = 0; e_ill = 0; e_dclr = 0;
    if (!v) begin
      e_tag = "R8";
    end else begin
      e_pc = pc + 32'd4;
      e_sup = s; e_et = e;
      if (s == 0 && e == 0) begin
        e_tag = "R2"; e_halt = 1;
      end else if (s == 0) begin
        e_tag = "R3";
      end else if (e == 1) begin
        e_tag = "R4"; e_ill = 1;
      end else if (dm == 0 && df == 0) begin
        e_tag = "R5"; e_pc = tpc; e_et = 1; e_sup = ps;
      end else if (dm == 1 && df == 1) begin
        e_tag = "R6"; e_pc = dpc; e_et = de; e_sup = ds; e_dclr = 1;
      end else begin
        e_tag = "R7";
      end
      if (pc > 32'hFFFF_FFFB && e_pc == pc + 32'd4) e_tag = "R9";
    end
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    e_tag = "R1";
    compare_all();
    rst = 0;
    @(negedge clk);
    compare_all(); // R1 first cycle after reset
    // R2 halt, debug inputs irrelevant
    drive(1, 32'h0000_1000, 0, 0, 1, 1, 1, 32'hAAAA_0000, 32'hBBBB_0000, 1, 1);
    // R8 idle: values held, pulses low
    drive(0, 32'h5555_5555, 1, 1, 1, 1, 1, 32'h1, 32'h2, 1, 1);
    // R3
    drive(1, 32'h0000_2000, 0, 1, 1, 0, 0, 32'hAAAA_0004, 32'hBBBB_0004, 0, 0);
    // R4 with matching normal-return fields: illegal wins
    drive(1, 32'h0000_3000, 1, 1, 0, 0, 0, 32'hAAAA_0008, 32'hBBBB_0008, 0, 0);
    // R4 with matching debug fields
    drive(1, 32'h0000_3100, 1, 1, 0, 1, 1, 32'hAAAA_0008, 32'hBBBB_0008, 0, 0);
    // R5 normal return, psup 0 then 1
    drive(1, 32'h0000_4000, 1, 0, 0, 0, 0, 32'hCAFE_0010, 32'hBBBB_000C, 1, 1);
    drive(1, 32'h0000_4004, 1, 0, 1, 0, 0, 32'hCAFE_0020, 32'hBBBB_000C, 1, 1);
    // R6 debug return with varied saved bits
    drive(1, 32'h0000_5000, 1, 0, 1, 1, 1, 32'hCAFE_0030, 32'hD00D_0040, 0, 1);
    drive(1, 32'h0000_5004, 1, 0, 1, 1, 1, 32'hCAFE_0030, 32'hD00D_0050, 1, 0);
    // R7 mismatches
    drive(1, 32'h0000_6000, 1, 0, 0, 1, 0, 32'hCAFE_0060, 32'hD00D_0060, 1, 1);
    drive(1, 32'h0000_6004, 1, 0, 0, 0, 1, 32'hCAFE_0060, 32'hD00D_0060, 1, 1);
    // R9 wrap
    drive(1, 32'hFFFF_FFFC, 0, 1, 0, 0, 0, 32'h0, 32'h0, 0, 0);
    drive(1, 32'hFFFF_FFFE, 1, 0, 1, 1, 0, 32'h0, 32'h0, 0, 0);
    // back-to-back strobes then idle
    drive(1, 32'h0000_7000, 1, 1, 0, 0, 0, 32'h0, 32'h0, 0, 0);
    drive(1, 32'h0000_7004, 0, 0, 0, 0, 0, 32'h0, 32'h0, 0, 0);
    drive(0, 32'h0, 0, 0, 0, 0, 0, 32'h0, 32'h0, 0, 0);
    drive(0, 32'h0, 1, 0, 0, 0, 0, 32'h0, 32'h0, 0, 0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      drive($urandom_range(0, 3) != 0, $urandom, 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom,
            1'($urandom), 1'($urandom));
    end
    // reset in mid-run returns to R1 state
    drive(1, 32'h0000_8000, 1, 0, 1, 0, 0, 32'h1234_5678, 32'h0, 0, 0);
    rst = 1;
    valid_i = 0;
    @(negedge clk);
    e_tag = "R1"; e_pc = '0; e_sup = 0; e_et = 0;
    e_done = 0; e_halt = 0; e_ill = 0; e_dclr = 0;
    compare_all();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule